// File: doc/BRIEF.md
# Doorbell-Driven Transfer Ring Consumer

This block sits on the device side of a host link. It follows one circular work ring per logical channel. Each channel carries traffic in one direction and owns exactly one ring. A context table keeps, for every channel, the ring's base address in host memory, a read index and a write index. The host fills ring elements, moves its write index forward, and then writes the new index into the channel's doorbell. The block compares the read index with the write index for every channel. It picks channels that have work in round-robin order and fetches one element per grant through a single-outstanding memory-read port. It then offers that element on a valid/ready consumer port.

When the consumer accepts an element, the channel's read index moves forward by one and wraps at the ring end. An element can mark itself as chained to the next one, so that several elements form one scatter-gather descriptor. When the accepted element has no chain mark, the block raises a descriptor-complete pulse that carries the channel number. A doorbell aimed at a channel index that the block does not implement changes nothing and raises an error pulse.

Top module: `xfer_ring_fetch`

## Requirements
- R1: After reset, el_valid, rd_req_valid, db_err and td_done are all low, and every ring is empty.
- R2: A cfg_valid write loads the channel's base address and sets both its read index and its write index to 0.
- R3: A doorbell to an implemented channel sets that channel's write index. The block then delivers, in order, the elements from the read index up to but not including the write index. A doorbell whose index equals the read index (an empty ring) delivers nothing.
- R4: The fetch address is base + read_index * 8, with 8 bytes per element. At most one element is in flight at any time. rd_req_valid and rd_req_addr stay unchanged until rd_req_ready.
- R5: el_data equals the memory response. el_valid, el_ch and el_data stay unchanged while el_ready is low.
- R6: Each accepted element advances its channel's read index by exactly one, modulo 16. A ring with write index equal to read index minus one (a full ring) delivers 15 elements.
- R7: After a grant to channel k, the next grant goes to the first channel with pending work in the cyclic order k+1, k+2, and so on. Each grant serves a single element.
- R8: td_done pulses, with td_done_ch set to the channel, in the cycle an element whose bit 0 (the chain flag) is 0 is accepted. No pulse occurs for an element whose bit 0 is 1.
- R9: A doorbell whose channel index is at or above the implemented count leaves every ring unchanged. It drives db_err high for exactly the following cycle.
- R10: A doorbell to an implemented channel never raises db_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Load a channel context |
| cfg_ch | input | 3 | Channel being configured |
| cfg_base | input | 32 | Ring base byte address |
| db_valid | input | 1 | Doorbell write strobe |
| db_ch | input | 8 | Doorbell channel index (full 256-entry space) |
| db_wp | input | 4 | New write index |
| db_err | output | 1 | Doorbell hit an unimplemented channel |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_req_addr | output | 32 | Element byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Ring element contents |
| el_valid | output | 1 | Element offered to consumer |
| el_ready | input | 1 | Consumer accepts element |
| el_ch | output | 3 | Channel of offered element |
| el_data | output | 64 | Offered element |
| td_done | output | 1 | Descriptor finished |
| td_done_ch | output | 3 | Channel of finished descriptor |

## Verification
On every cycle, the assertions check the following. The memory request and the consumer offer stay stable under backpressure. A fetch and an offer never overlap. A fetch only starts for a channel whose ring holds work. A read index never advances past its write index. Every error pulse traces back to a doorbell for an unimplemented channel. Only the bench's scenarios can show what the data means: the exact order of round-robin grants across channels, the wrap of the read index, the fifteen-element full ring, where descriptor boundaries fall in chained elements, and the fact that an ignored doorbell really left every ring untouched.

// File: rtl/ring_pkg.sv
package ring_pkg;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_REQ  = 2'd1,
      S_WAIT = 2'd2,
      S_OUT  = 2'd3
   } fetch_state_t;

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N  = 8,
   parameter int CW = 3
) (
   input  logic [N-1:0]  req,
   input  logic [CW-1:0] last,
   output logic          found,
   output logic [CW-1:0] idx
);

   generate
      if (N == 1) begin : g_single
         always_comb begin
            found = req[0];
            idx   = '0;
         end
      end else begin : g_rotate
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int k = 1; k <= N; k++) begin
               if (!found && req[(int'(last) + k) % N]) begin
                  found = 1'b1;
                  idx   = CW'((int'(last) + k) % N);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ring_ctx_table.sv
module ring_ctx_table #(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = 4,
   parameter int ADDR_W = 32,
   parameter int CW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic [CW-1:0]     cfg_ch,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              db_wr,
   input  logic [CW-1:0]     db_ch,
   input  logic [IDX_W-1:0]  db_wp,
   input  logic              adv,
   input  logic [CW-1:0]     adv_ch,
   input  logic [CW-1:0]     sel_ch,
   output logic [ADDR_W-1:0] sel_base,
   output logic [IDX_W-1:0]  sel_rp,
   output logic [NUM_CH-1:0] pending
);

   logic [ADDR_W-1:0] base_r [NUM_CH];
   logic [IDX_W-1:0]  rp_r   [NUM_CH];
   logic [IDX_W-1:0]  wp_r   [NUM_CH];

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               base_r[g] <= '0;
               rp_r[g]   <= '0;
               wp_r[g]   <= '0;
            end else if (cfg_valid && cfg_ch == CW'(g)) begin
               base_r[g] <= cfg_base;
               rp_r[g]   <= '0;
               wp_r[g]   <= '0;
            end else begin
               if (db_wr && db_ch == CW'(g)) wp_r[g] <= db_wp;
               if (adv && adv_ch == CW'(g))  rp_r[g] <= rp_r[g] + 1'b1;
            end
         end

         assign pending[g] = (rp_r[g] != wp_r[g]);

         // R6: the consumer side never moves a read index past its write index
         a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && adv_ch == CW'(g)) |-> (rp_r[g] != wp_r[g]));
      end
   endgenerate

   assign sel_base = base_r[sel_ch];
   assign sel_rp   = rp_r[sel_ch];

endmodule

// File: rtl/xfer_ring_fetch.sv
module xfer_ring_fetch
   import ring_pkg::*;
#(
   parameter int NUM_CH     = 8,
   parameter int RING_DEPTH = 16,
   parameter int ADDR_W     = 32,
   parameter int ELEM_W     = 64,
   parameter int ELEM_BYTES = 8,
   parameter int DB_CH_W    = 8,
   parameter int CHAIN_POS  = 0,
   localparam int CW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int IDX_W     = $clog2(RING_DEPTH),
   localparam int SHIFT     = $clog2(ELEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic [CW-1:0]     cfg_ch,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              db_valid,
   input  logic [DB_CH_W-1:0] db_ch,
   input  logic [IDX_W-1:0]  db_wp,
   output logic              db_err,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   input  logic              rd_rsp_valid,
   input  logic [ELEM_W-1:0] rd_rsp_data,
   output logic              el_valid,
   input  logic              el_ready,
   output logic [CW-1:0]     el_ch,
   output logic [ELEM_W-1:0] el_data,
   output logic              td_done,
   output logic [CW-1:0]     td_done_ch
);

   initial begin : p_param_chk
      assert (NUM_CH >= 1 && NUM_CH <= (1 << DB_CH_W))
         else $fatal(1, "channel count outside doorbell index space");
      assert (RING_DEPTH >= 2 && RING_DEPTH == (1 << IDX_W))
         else $fatal(1, "ring depth must be a power of two");
      assert (ELEM_BYTES == (1 << SHIFT))
         else $fatal(1, "element size must be a power of two");
      assert (CHAIN_POS >= 0 && CHAIN_POS < ELEM_W)
         else $fatal(1, "chain flag outside element");
   end

   fetch_state_t      state_q;
   logic [CW-1:0]     cur_ch_q;
   logic [CW-1:0]     last_ch_q;
   logic [ELEM_W-1:0] elem_q;
   logic              db_ok;
   logic [NUM_CH-1:0] pending;
   logic              gnt_found;
   logic [CW-1:0]     gnt_idx;
   logic [ADDR_W-1:0] sel_base;
   logic [IDX_W-1:0]  sel_rp;
   logic              accept;

   assign db_ok  = db_valid && (int'(db_ch) < NUM_CH);
   assign accept = (state_q == S_OUT) && el_ready;

   ring_ctx_table #(
      .NUM_CH (NUM_CH),
      .IDX_W  (IDX_W),
      .ADDR_W (ADDR_W),
      .CW     (CW)
   ) ctx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_valid (cfg_valid),
      .cfg_ch    (cfg_ch),
      .cfg_base  (cfg_base),
      .db_wr     (db_ok),
      .db_ch     (CW'(db_ch)),
      .db_wp     (db_wp),
      .adv       (accept),
      .adv_ch    (cur_ch_q),
      .sel_ch    (cur_ch_q),
      .sel_base  (sel_base),
      .sel_rp    (sel_rp),
      .pending   (pending)
   );

   rr_pick #(
      .N  (NUM_CH),
      .CW (CW)
   ) arb_i (
      .req   (pending),
      .last  (last_ch_q),
      .found (gnt_found),
      .idx   (gnt_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         cur_ch_q  <= '0;
         last_ch_q <= CW'(NUM_CH - 1);
         elem_q    <= '0;
         db_err    <= 1'b0;
      end else begin
         db_err <= db_valid && !db_ok;
         unique case (state_q)
            S_IDLE: if (gnt_found) begin
               cur_ch_q  <= gnt_idx;
               last_ch_q <= gnt_idx;
               state_q   <= S_REQ;
            end
            S_REQ:  if (rd_req_ready) state_q <= S_WAIT;
            S_WAIT: if (rd_rsp_valid) begin
               elem_q  <= rd_rsp_data;
               state_q <= S_OUT;
            end
            S_OUT:  if (el_ready) state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign rd_req_valid = (state_q == S_REQ);
   assign rd_req_addr  = sel_base + (ADDR_W'(sel_rp) << SHIFT);
   assign el_valid     = (state_q == S_OUT);
   assign el_ch        = cur_ch_q;
   assign el_data      = elem_q;
   assign td_done      = accept && !elem_q[CHAIN_POS];
   assign td_done_ch   = cur_ch_q;

   // R4: request held steady under backpressure
   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

   // R4: never a fetch while an element is still on offer
   a_r4_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> !el_valid);

   // R5: offer held steady under backpressure
   a_r5_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (el_valid && !el_ready) |=> (el_valid && $stable(el_data) && $stable(el_ch)));

   // R7: a fetch is only issued for a channel that holds work
   a_r7_served_pending: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> pending[cur_ch_q]);

   // R9: every error pulse follows a doorbell outside the implemented range
   a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      db_err |-> ($past(db_valid) && int'($past(db_ch)) >= NUM_CH));

endmodule

// File: tb/xfer_ring_fetch_tb_top.sv
`timescale 1ns/1ps
module xfer_ring_fetch_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_valid;
   logic [2:0]  cfg_ch;
   logic [31:0] cfg_base;
   logic        db_valid;
   logic [7:0]  db_ch;
   logic [3:0]  db_wp;
   logic        db_err;
   logic        rd_req_valid;
   logic        rd_req_ready;
   logic [31:0] rd_req_addr;
   logic        rd_rsp_valid;
   logic [63:0] rd_rsp_data;
   logic        el_valid;
   logic        el_ready;
   logic [2:0]  el_ch;
   logic [63:0] el_data;
   logic        td_done;
   logic [2:0]  td_done_ch;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 0;

   bit chain_tbl [8][16];

   int          mon_n = 0;
   logic [2:0]  mon_ch   [64];
   logic [63:0] mon_data [64];
   logic        mon_done [64];
   logic [2:0]  mon_dch  [64];

   always #2 clk = ~clk;

   xfer_ring_fetch dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_valid    (cfg_valid),
      .cfg_ch       (cfg_ch),
      .cfg_base     (cfg_base),
      .db_valid     (db_valid),
      .db_ch        (db_ch),
      .db_wp        (db_wp),
      .db_err       (db_err),
      .rd_req_valid (rd_req_valid),
      .rd_req_ready (rd_req_ready),
      .rd_req_addr  (rd_req_addr),
      .rd_rsp_valid (rd_rsp_valid),
      .rd_rsp_data  (rd_rsp_data),
      .el_valid     (el_valid),
      .el_ready     (el_ready),
      .el_ch        (el_ch),
      .el_data      (el_data),
      .td_done      (td_done),
      .td_done_ch   (td_done_ch)
   );

   // memory model: base of channel c is c*0x1000, element index in addr[6:3]
   function automatic logic [63:0] mem_word(input logic [31:0] a);
      return {a, 8'h5A, 23'h0, chain_tbl[a[14:12]][a[6:3]]};
   endfunction

   always @(posedge clk) begin
      rd_rsp_valid <= rd_req_valid && rd_req_ready;
      rd_rsp_data  <= mem_word(rd_req_addr);
   end

   always @(negedge clk) begin
      if (el_valid && el_ready && mon_n < 64) begin
         mon_ch[mon_n]   <= el_ch;
         mon_data[mon_n] <= el_data;
         mon_done[mon_n] <= td_done;
         mon_dch[mon_n]  <= td_done_ch;
         mon_n           <= mon_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic cfg(input int ch);
      step();
      cfg_valid = 1; cfg_ch = 3'(ch); cfg_base = 32'(ch * 32'h1000);
      step();
      cfg_valid = 0;
   endtask

   task automatic ring(input int ch, input int wp);
      step();
      db_valid = 1; db_ch = 8'(ch); db_wp = 4'(wp);
      step();
      db_valid = 0;
   endtask

   task automatic wait_elems(input int n);
      int t = 0;
      while (mon_n < n && t < 3000) begin
         @(negedge clk); t++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_elem(input int k, input int ch, input int idx, input string req);
      logic [31:0] a;
      a = 32'(ch * 32'h1000 + idx * 8);
      chk(mon_ch[k] == 3'(ch), req, "element channel", 64'(mon_ch[k]), 64'(ch));
      chk(mon_data[k] == mem_word(a), req, "element data", mon_data[k], mem_word(a));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!el_valid && !rd_req_valid, "R1", "idle outputs", {62'd0, el_valid, rd_req_valid}, 0);
      chk(!db_err && !td_done, "R1", "idle pulses", {62'd0, db_err, td_done}, 0);
   endtask

   task automatic t_basic();
      mon_n = 0;
      cfg(0);                            // R2 base 0x0000, indices cleared
      ring(0, 3);
      wait_elems(3);
      chk(mon_n == 3, "R3", "count ch0", 64'(mon_n), 3);
      for (int k = 0; k < 3; k++) chk_elem(k, 0, k, "R4");
      chk(mon_done[2] && mon_dch[2] == 0, "R8", "done on unchained", 64'(mon_done[2]), 1);
   endtask

   task automatic t_chain();
      mon_n = 0;
      chain_tbl[1][0] = 1; chain_tbl[1][1] = 1;
      cfg(1);
      ring(1, 4);
      wait_elems(4);
      chk(mon_n == 4, "R3", "count ch1", 64'(mon_n), 4);
      chk(!mon_done[0] && !mon_done[1], "R8", "no done on chained",
          {62'd0, mon_done[0], mon_done[1]}, 0);
      chk(mon_done[2] && mon_done[3] && mon_dch[2] == 1 && mon_dch[3] == 1, "R8",
          "done closes descriptor", {62'd0, mon_done[2], mon_done[3]}, 3);
   endtask

   task automatic t_round_robin();
      int exp_ch [5] = '{2, 3, 5, 2, 5};
      int exp_ix [5] = '{0, 0, 0, 1, 1};
      mon_n = 0;
      cfg(2); cfg(3); cfg(5);
      step(); el_ready = 0;
      ring(2, 2);
      ring(3, 1);
      ring(5, 2);
      repeat (8) @(negedge clk);
      chk(el_valid && el_ch == 2, "R5", "offer held while stalled", 64'(el_ch), 2);
      step(); el_ready = 1;
      wait_elems(5);
      chk(mon_n == 5, "R7", "rr count", 64'(mon_n), 5);
      for (int k = 0; k < 5; k++) chk_elem(k, exp_ch[k], exp_ix[k], "R7");
   endtask

   task automatic t_wrap_full();
      mon_n = 0;
      cfg(4);
      ring(4, 14);
      wait_elems(14);
      chk(mon_n == 14, "R6", "first pass", 64'(mon_n), 14);
      mon_n = 0;
      ring(4, 2);
      wait_elems(4);
      chk(mon_n == 4, "R6", "wrap count", 64'(mon_n), 4);
      chk_elem(1, 4, 15, "R6");
      chk_elem(2, 4, 0, "R6");
      mon_n = 0;
      ring(4, 1);                        // read index 2, write 1: full ring
      wait_elems(15);
      chk(mon_n == 15, "R6", "full ring delivers 15", 64'(mon_n), 15);
      chk_elem(14, 4, 0, "R6");
   endtask

   task automatic t_empty();
      mon_n = 0;
      cfg(6);
      ring(6, 0);
      repeat (20) @(negedge clk);
      chk(mon_n == 0, "R3", "empty ring silent", 64'(mon_n), 0);
   endtask

   task automatic t_mem_stall();
      mon_n = 0;
      cfg(7);
      step(); rd_req_ready = 0;
      ring(7, 2);
      repeat (6) @(negedge clk);
      chk(rd_req_valid && rd_req_addr == 32'h7000, "R4", "request held",
          64'(rd_req_addr), 64'h7000);
      step(); rd_req_ready = 1;
      wait_elems(2);
      chk(mon_n == 2, "R4", "stall count", 64'(mon_n), 2);
      chk_elem(1, 7, 1, "R5");
   endtask

   task automatic t_bad_doorbell();
      mon_n = 0;
      step();
      db_valid = 1; db_ch = 8'd8; db_wp = 4'd9;
      step();
      db_valid = 0;
      @(negedge clk);
      chk(db_err, "R9", "err pulse ch8", 64'(db_err), 1);
      @(negedge clk);
      chk(!db_err, "R9", "err one cycle", 64'(db_err), 0);
      ring(200, 5);
      repeat (20) @(negedge clk);
      chk(mon_n == 0 && !el_valid, "R9", "no ring changed", 64'(mon_n), 0);
      step();
      db_valid = 1; db_ch = 8'd0; db_wp = 4'd3;   // equals rp: no work, no error
      step();
      db_valid = 0;
      @(negedge clk);
      chk(!db_err, "R10", "valid doorbell no err", 64'(db_err), 0);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      rst_n = 0; cfg_valid = 0; cfg_ch = 0; cfg_base = 0;
      db_valid = 0; db_ch = 0; db_wp = 0;
      rd_req_ready = 1; el_ready = 1;
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_basic();
      t_chain();
      t_round_robin();
      t_wrap_full();
      t_empty();
      t_mem_stall();
      t_bad_doorbell();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule